// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block sits between a host-visible command-issue vector and a single command execution engine. The host marks command slots as pending by writing bits into the vector. The block walks the pending slots in ascending index order and hands them to the engine one at a time. Each hand-off is a one-cycle dispatch strobe that carries the slot index. The engine answers in the cycle after the strobe. If it is idle again, the command finished at once and its pending bit is dropped. If it is still busy, the slot is kept pending and is recorded as the busy slot.

A busy slot is released only by a later completion event that arrives while the engine has gone idle. The release clears the slot's pending bit, empties the record and starts a fresh walk from slot 0. A port reset empties the busy record and abandons any walk in progress. Host writes, completion events and the rising edge of the port start enable each trigger a walk. A trigger that arrives while a walk is already running is remembered and starts a new walk from slot 0 once the current one ends.

Top module: `cmd_slot_sched`

## Requirements
- R1: No dispatch happens while `start_en_i` is low. A walk started with the enable low, or with an empty vector, ends without a dispatch.
- R2: Within a walk, slots are dispatched lowest index first. After slot k is dispatched, the walk continues from index k+1 upward, and `dispatch_slot_o` always names a pending slot.
- R3: If `eng_busy_i` is high when a slot would be dispatched, nothing is dispatched, the pending bit stays set and the walk ends.
- R4: If `eng_busy_i` is low in the cycle after a dispatch, the slot's bit in `issue_o` reads 0 from the following cycle on.
- R5: If `eng_busy_i` is high in the cycle after a dispatch, then from the next cycle `busy_vld_o` is 1, `busy_slot_o` holds the slot index and the slot's bit stays set. While `busy_vld_o` is 1, no dispatch occurs.
- R6: An `eng_done_i` pulse with `busy_vld_o` high and `eng_busy_i` low clears the recorded slot's bit and `busy_vld_o` in the next cycle, and starts a walk from slot 0.
- R7: An `eng_done_i` pulse while `eng_busy_i` is high leaves the busy record and its pending bit unchanged.
- R8: A write (`issue_wr_en_i`) ORs `issue_wr_data_i` into the vector, with bit i standing for slot i. A write never clears a bit, and every write triggers a walk, even a write of all zeros. After reset the vector is all zeros.
- R9: `port_rst_i` makes `busy_vld_o` 0 in the next cycle, abandons the current walk and leaves the pending bits untouched.
- R10: `dispatch_o` is a single-cycle pulse, and the cycle after a dispatch never carries another one.
- R11: A trigger that arrives during a walk is remembered. When the walk ends, a new walk starts from slot 0. A rising edge of `start_en_i` also triggers a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_en_i | input | 1 | Port start enable; its rising edge triggers a walk |
| issue_wr_en_i | input | 1 | Host write strobe for the issue vector |
| issue_wr_data_i | input | NSLOT | Bits to OR into the issue vector |
| eng_busy_i | input | 1 | Engine occupied (busy or data-request status) |
| eng_done_i | input | 1 | Engine completion event |
| port_rst_i | input | 1 | Port reset: empties the busy record |
| dispatch_o | output | 1 | One-cycle dispatch strobe |
| dispatch_slot_o | output | $clog2(NSLOT) | Slot index being dispatched |
| issue_o | output | NSLOT | Current pending-slot vector |
| busy_vld_o | output | 1 | A busy slot is recorded |
| busy_slot_o | output | $clog2(NSLOT) | Index of the recorded busy slot |

## Verification
The hardest case to reach is a trigger that lands in the middle of a walk. A new bit has to be written below the walk's current position exactly while a dispatch result is pending. If that trigger were lost, the slot would sit unserved until some later event. The bench reaches this case deterministically: it writes slot 2 in the result cycle of slot 10 and expects the order 10, 20, 2. A cycle-level reference model also follows long random runs. In those runs, completions arrive while the engine is still busy, port resets drop the busy record under a running engine, and foreign busy periods block the walk, so each of these orderings is exercised many times.

// File: rtl/cmd_sched_pkg.sv
// Shared types for the command slot scheduler.
package cmd_sched_pkg;
    // Walk controller states.
    typedef enum logic [1:0] {
        SCH_IDLE   = 2'd0,
        SCH_SCAN   = 2'd1,
        SCH_RESULT = 2'd2
    } sched_state_e;
endpackage

// File: rtl/slot_picker.sv
// Finds the lowest pending slot whose index is at or above a floor index.
// Assumes NSLOT >= 2. A floor of NSLOT or above yields no candidate.
module slot_picker #(
    parameter int NSLOT = 32,
    parameter int PW    = 6,
    parameter int IW    = 5
) (
    input  logic [NSLOT-1:0] pend_vec,
    input  logic [PW-1:0]    floor_idx,
    output logic             found,
    output logic [IW-1:0]    pick_idx
);
    logic [NSLOT-1:0] eligible;

    // Mask off slots below the floor.
    for (genvar g = 0; g < NSLOT; g++) begin : g_elig
        localparam logic [PW-1:0] POS = PW'(g);
        assign eligible[g] = pend_vec[g] & (POS >= floor_idx);
    end

    // Priority encode, lowest index wins.
    always_comb begin
        found    = |eligible;
        pick_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                pick_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/issue_vector.sv
// Holds the pending-slot vector: clears apply to the old contents, then
// host bits are ORed in, so a bit written in a clearing cycle survives.
module issue_vector #(
    parameter int NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [NSLOT-1:0] set_bits,
    input  logic [NSLOT-1:0] clr_bits,
    output logic [NSLOT-1:0] vec_q
);
    // Merge host bits and retire finished slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            vec_q <= (vec_q & ~clr_bits) | (set_en ? set_bits : '0);
        end
    end
endmodule

// File: rtl/busy_tracker.sv
// Keeps the record of the slot left running on the engine (valid + index)
// and decides when a completion event retires it.
// Assumes capture and retire are never requested in the same cycle.
module busy_tracker #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_rst,
    input  logic          capture_en,
    input  logic [IW-1:0] capture_idx,
    input  logic          done_evt,
    input  logic          eng_busy,
    output logic          rec_vld,
    output logic [IW-1:0] rec_idx,
    output logic          retire
);
    // A completion retires the record only once the engine is idle.
    assign retire = done_evt & rec_vld & ~eng_busy;

    // Record update; port reset wins over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_vld <= 1'b0;
            rec_idx <= '0;
        end else if (port_rst) begin
            rec_vld <= 1'b0;
        end else if (capture_en) begin
            rec_vld <= 1'b1;
            rec_idx <= capture_idx;
        end else if (retire) begin
            rec_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/cmd_slot_sched.sv
// Command slot scheduler: walks the pending vector upward from slot 0 and
// dispatches one slot at a time to a single engine. The engine reports its
// result through eng_busy_i in the cycle after a dispatch strobe.
// Assumes the engine raises eng_busy_i in that cycle for any command it
// has not finished, and holds it until it signals completion.
module cmd_slot_sched #(
    parameter int NSLOT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_en_i,
    input  logic                     issue_wr_en_i,
    input  logic [NSLOT-1:0]         issue_wr_data_i,
    input  logic                     eng_busy_i,
    input  logic                     eng_done_i,
    input  logic                     port_rst_i,
    output logic                     dispatch_o,
    output logic [$clog2(NSLOT)-1:0] dispatch_slot_o,
    output logic [NSLOT-1:0]         issue_o,
    output logic                     busy_vld_o,
    output logic [$clog2(NSLOT)-1:0] busy_slot_o
);
    import cmd_sched_pkg::*;

    localparam int IW = $clog2(NSLOT);
    localparam int PW = $clog2(NSLOT + 1);
    localparam logic [NSLOT-1:0] ONE_HOT0 = NSLOT'(1);

    sched_state_e     st_q, st_n;
    logic [PW-1:0]    ptr_q, ptr_n;
    logic [IW-1:0]    cur_q, cur_n;
    logic             pend_q, pend_n;
    logic             start_q;
    logic             pick_found;
    logic [IW-1:0]    pick_idx;
    logic             rec_vld;
    logic [IW-1:0]    rec_idx;
    logic             retire;
    logic             trig;
    logic             go;
    logic             result_busy;
    logic             result_done;
    logic [NSLOT-1:0] clr_bits;
    logic [NSLOT-1:0] issue_q;

    // Events that request a walk.
    assign trig = issue_wr_en_i | eng_done_i | (start_en_i & ~start_q);

    // Dispatch only from a walk, when enabled, idle and with nothing held.
    assign go = (st_q == SCH_SCAN) & start_en_i & pick_found & ~eng_busy_i & ~rec_vld;

    // Engine verdict in the cycle after a dispatch.
    assign result_busy = (st_q == SCH_RESULT) & eng_busy_i;
    assign result_done = (st_q == SCH_RESULT) & ~eng_busy_i;

    // Bits to drop: a synchronously finished slot and a retired busy slot.
    assign clr_bits = (result_done ? (ONE_HOT0 << cur_q) : '0)
                    | (retire ? (ONE_HOT0 << rec_idx) : '0);

    slot_picker #(.NSLOT(NSLOT), .PW(PW), .IW(IW)) picker_i (
        .pend_vec  (issue_q),
        .floor_idx (ptr_q),
        .found     (pick_found),
        .pick_idx  (pick_idx)
    );

    issue_vector #(.NSLOT(NSLOT)) issue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue_wr_en_i),
        .set_bits (issue_wr_data_i),
        .clr_bits (clr_bits),
        .vec_q    (issue_q)
    );

    busy_tracker #(.IW(IW)) tracker_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_rst    (port_rst_i),
        .capture_en  (result_busy),
        .capture_idx (cur_q),
        .done_evt    (eng_done_i),
        .eng_busy    (eng_busy_i),
        .rec_vld     (rec_vld),
        .rec_idx     (rec_idx),
        .retire      (retire)
    );

    // Walk controller next-state logic.
    always_comb begin
        st_n   = st_q;
        ptr_n  = ptr_q;
        cur_n  = cur_q;
        pend_n = pend_q;
        if (port_rst_i) begin
            st_n   = SCH_IDLE;
            ptr_n  = '0;
            pend_n = 1'b0;
        end else begin
            unique case (st_q)
                SCH_IDLE: begin
                    if (trig) begin
                        st_n   = SCH_SCAN;
                        ptr_n  = '0;
                        pend_n = 1'b0;
                    end
                end
                SCH_SCAN: begin
                    if (go) begin
                        st_n   = SCH_RESULT;
                        cur_n  = pick_idx;
                        ptr_n  = PW'(pick_idx) + PW'(1);
                        pend_n = pend_q | trig;
                    end else if (pend_q | trig) begin
                        st_n   = SCH_SCAN;
                        ptr_n  = '0;
                        pend_n = 1'b0;
                    end else begin
                        st_n   = SCH_IDLE;
                    end
                end
                SCH_RESULT: begin
                    st_n   = SCH_SCAN;
                    pend_n = pend_q | trig;
                end
                default: begin
                    st_n   = SCH_IDLE;
                end
            endcase
        end
    end

    // Walk controller registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SCH_IDLE;
            ptr_q   <= '0;
            cur_q   <= '0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            ptr_q   <= ptr_n;
            cur_q   <= cur_n;
            pend_q  <= pend_n;
            start_q <= start_en_i;
        end
    end

    assign dispatch_o      = go;
    assign dispatch_slot_o = pick_idx;
    assign issue_o         = issue_q;
    assign busy_vld_o      = rec_vld;
    assign busy_slot_o     = rec_idx;
endmodule

// File: rtl/cmd_slot_sched_chk.sv
// Property checker for the command slot scheduler, bound to every instance.
module cmd_slot_sched_chk #(
    parameter int NSLOT = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_en_i,
    input logic                     issue_wr_en_i,
    input logic [NSLOT-1:0]         issue_wr_data_i,
    input logic                     eng_busy_i,
    input logic                     eng_done_i,
    input logic                     port_rst_i,
    input logic                     dispatch_o,
    input logic [$clog2(NSLOT)-1:0] dispatch_slot_o,
    input logic [NSLOT-1:0]         issue_o,
    input logic                     busy_vld_o,
    input logic [$clog2(NSLOT)-1:0] busy_slot_o
);
    AST_DISP_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> start_en_i); // R1
    AST_DISP_SLOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> issue_o[dispatch_slot_o]); // R2
    AST_NO_DISP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |-> !eng_busy_i); // R3
    AST_NO_DISP_WITH_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_vld_o |-> !dispatch_o); // R5
    AST_RECORD_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        busy_vld_o |-> issue_o[busy_slot_o]); // R5
    AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vld_o && eng_done_i && !eng_busy_i && !issue_wr_en_i)
        |=> (!busy_vld_o && !issue_o[$past(busy_slot_o)])); // R6
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vld_o && eng_done_i && eng_busy_i && !port_rst_i)
        |=> (busy_vld_o && busy_slot_o == $past(busy_slot_o))); // R7
    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        issue_wr_en_i |=> ((issue_o & $past(issue_wr_data_i)) == $past(issue_wr_data_i))); // R8
    AST_PORT_RST_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        port_rst_i |=> !busy_vld_o); // R9
    AST_DISP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_o |=> !dispatch_o); // R10
endmodule

bind cmd_slot_sched cmd_slot_sched_chk #(.NSLOT(NSLOT)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_en_i      (start_en_i),
    .issue_wr_en_i   (issue_wr_en_i),
    .issue_wr_data_i (issue_wr_data_i),
    .eng_busy_i      (eng_busy_i),
    .eng_done_i      (eng_done_i),
    .port_rst_i      (port_rst_i),
    .dispatch_o      (dispatch_o),
    .dispatch_slot_o (dispatch_slot_o),
    .issue_o         (issue_o),
    .busy_vld_o      (busy_vld_o),
    .busy_slot_o     (busy_slot_o)
);

// File: tb/cmd_slot_sched_tb_top.sv
// Bench: behavioural cycle model compared every clock, an engine model with
// random latency, and directed phases for each requirement.
module cmd_slot_sched_tb_top;
    localparam int NSLOT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_en_i = 1'b0;
    logic        issue_wr_en_i = 1'b0;
    logic [31:0] issue_wr_data_i = '0;
    logic        eng_busy_i = 1'b0;
    logic        eng_done_i = 1'b0;
    logic        port_rst_i = 1'b0;
    logic        dispatch_o;
    logic [4:0]  dispatch_slot_o;
    logic [31:0] issue_o;
    logic        busy_vld_o;
    logic [4:0]  busy_slot_o;

    always #10 clk = ~clk;

    cmd_slot_sched #(.NSLOT(NSLOT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_en_i(start_en_i),
        .issue_wr_en_i(issue_wr_en_i), .issue_wr_data_i(issue_wr_data_i),
        .eng_busy_i(eng_busy_i), .eng_done_i(eng_done_i), .port_rst_i(port_rst_i),
        .dispatch_o(dispatch_o), .dispatch_slot_o(dispatch_slot_o), .issue_o(issue_o),
        .busy_vld_o(busy_vld_o), .busy_slot_o(busy_slot_o)
    );

    int total = 0;
    int bad = 0;

    // stimulus controls
    bit        s_start = 0, s_wr = 0, s_done = 0, s_prst = 0, f_busy = 0;
    bit [31:0] s_wdata = '0;
    // engine model
    int e_cnt = 0;
    bit e_done = 0;
    int mode = 0;       // 0 sync, 1 async, 2 random
    int lat_lo = 1, lat_hi = 1;
    // reference model state
    bit [31:0] m_issue = '0;
    int m_st = 0, m_ptr = 0, m_cur = 0, m_bidx = 0;
    bit m_bvld = 0, m_pend = 0, m_startq = 0;
    int disp_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_q();
        logic [31:0] v = '0;
        foreach (disp_q[i]) v = (v << 8) | 32'(disp_q[i] + 1);
        return v;
    endfunction

    // One clock: drive, compare against the model, advance model and engine.
    task automatic step();
        bit busy, done, found, go, trig, accept;
        int pick, n_st, n_ptr, n_cur, n_bidx;
        bit n_pend, n_bvld;
        bit [31:0] clr, n_issue;
        @(negedge clk);
        start_en_i      = s_start;
        issue_wr_en_i   = s_wr;
        issue_wr_data_i = s_wdata;
        port_rst_i      = s_prst;
        busy            = (e_cnt > 0) || f_busy;
        done            = e_done || s_done;
        eng_busy_i      = busy;
        eng_done_i      = done;
        #1;
        found = 0; pick = 0;
        if (m_st == 1) begin
            for (int i = NSLOT - 1; i >= m_ptr; i--) begin
                if (m_issue[i]) begin found = 1; pick = i; end
            end
        end
        go = (m_st == 1) && s_start && found && !busy && !m_bvld;
        chk(dispatch_o === go, "R1 R3 R10 dispatch strobe", 32'(dispatch_o), 32'(go));
        if (go) chk(dispatch_slot_o == 5'(pick), "R2 dispatch slot", 32'(dispatch_slot_o), 32'(pick));
        chk(issue_o === m_issue, "R4 R6 R8 issue vector", issue_o, m_issue);
        chk(busy_vld_o === m_bvld, "R5 R9 busy record valid", 32'(busy_vld_o), 32'(m_bvld));
        if (m_bvld) chk(busy_slot_o == 5'(m_bidx), "R5 busy record index", 32'(busy_slot_o), 32'(m_bidx));
        if (dispatch_o) disp_q.push_back(int'(dispatch_slot_o));
        // model next state
        trig   = s_wr || done || (s_start && !m_startq);
        accept = done && m_bvld && !busy;
        clr = '0;
        if (m_st == 2 && !busy) clr[m_cur] = 1'b1;
        if (accept) clr[m_bidx] = 1'b1;
        n_issue = (m_issue & ~clr) | (s_wr ? s_wdata : 32'h0);
        n_bvld = m_bvld; n_bidx = m_bidx;
        if (s_prst) n_bvld = 0;
        else if (m_st == 2 && busy) begin n_bvld = 1; n_bidx = m_cur; end
        else if (accept) n_bvld = 0;
        n_st = m_st; n_ptr = m_ptr; n_cur = m_cur; n_pend = m_pend;
        if (s_prst) begin n_st = 0; n_ptr = 0; n_pend = 0; end
        else if (m_st == 0) begin
            if (trig) begin n_st = 1; n_ptr = 0; n_pend = 0; end
        end else if (m_st == 1) begin
            if (go) begin n_st = 2; n_cur = pick; n_ptr = pick + 1; n_pend = m_pend || trig; end
            else if (m_pend || trig) begin n_st = 1; n_ptr = 0; n_pend = 0; end
            else n_st = 0;
        end else begin
            n_st = 1; n_pend = m_pend || trig;
        end
        m_issue = n_issue; m_bvld = n_bvld; m_bidx = n_bidx;
        m_st = n_st; m_ptr = n_ptr; m_cur = n_cur; m_pend = n_pend; m_startq = s_start;
        // engine model
        e_done = 0;
        if (e_cnt > 0) begin
            e_cnt--;
            if (e_cnt == 0) e_done = 1;
        end
        if (dispatch_o) begin
            if (mode == 1 || (mode == 2 && ($urandom % 2) == 1))
                e_cnt = lat_lo + int'($urandom % 32'(lat_hi - lat_lo + 1));
        end
        s_wr = 0; s_done = 0; s_prst = 0;
    endtask

    task automatic write_bits(input bit [31:0] b);
        s_wr = 1; s_wdata = b; step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(issue_o == 0, "R8 reset vector empty", issue_o, 0);
        chk(busy_vld_o == 0, "R9 reset record empty", 32'(busy_vld_o), 0);
        chk(dispatch_o == 0, "R1 reset no dispatch", 32'(dispatch_o), 0);

        // R1: writes with start low are held but never dispatched
        write_bits(32'h0000_000F);
        repeat (10) step();
        chk(disp_q.size() == 0, "R1 no dispatch while stopped", disp_q.size(), 0);
        chk(issue_o == 32'hF, "R8 write merged", issue_o, 32'hF);

        // R2 R4 R11: start rising edge walks slots in order, sync finish
        mode = 0; disp_q.delete(); s_start = 1;
        repeat (20) step();
        chk(pack_q() == 32'h01020304, "R2 ascending order", pack_q(), 32'h01020304);
        chk(issue_o == 0, "R4 sync bits cleared", issue_o, 0);

        // R5 R6: async slot is held, retired by completion, then rescan
        mode = 1; lat_lo = 6; lat_hi = 6; disp_q.delete();
        write_bits((32'h1 << 5) | (32'h1 << 9));
        repeat (3) step();
        chk(busy_vld_o == 1, "R5 record valid", 32'(busy_vld_o), 1);
        chk(busy_slot_o == 5, "R5 record index", 32'(busy_slot_o), 5);
        chk(issue_o[5] == 1, "R5 held bit stays", 32'(issue_o[5]), 1);
        chk(disp_q.size() == 1, "R5 single outstanding", disp_q.size(), 1);
        mode = 0;
        repeat (20) step();
        chk(pack_q() == 32'h0000060A, "R6 retire then rescan", pack_q(), 32'h0000060A);
        chk(issue_o == 0 && busy_vld_o == 0, "R6 all retired", issue_o, 0);

        // R7: completion while engine still busy is ignored
        mode = 1; lat_lo = 40; lat_hi = 40;
        write_bits(32'h1 << 12);
        repeat (4) step();
        mode = 0;
        s_done = 1; step(); step();
        chk(busy_vld_o == 1, "R7 record kept", 32'(busy_vld_o), 1);
        chk(issue_o[12] == 1, "R7 bit kept", 32'(issue_o[12]), 1);
        repeat (60) step();
        chk(issue_o == 0 && busy_vld_o == 0, "R6 late retire", issue_o, 0);

        // R3 R8: engine occupied elsewhere blocks the walk; empty write rescans
        disp_q.delete(); f_busy = 1;
        write_bits(32'h18);
        repeat (6) step();
        chk(disp_q.size() == 0, "R3 no dispatch while busy", disp_q.size(), 0);
        chk(issue_o == 32'h18, "R3 bits remain", issue_o, 32'h18);
        f_busy = 0;
        write_bits(32'h0);
        repeat (12) step();
        chk(pack_q() == 32'h00000405, "R8 empty write triggers", pack_q(), 32'h00000405);

        // R9: port reset drops the record, keeps the bit
        mode = 1; lat_lo = 30; lat_hi = 30;
        write_bits(32'h1 << 7);
        repeat (4) step();
        chk(busy_vld_o == 1, "R9 record before reset", 32'(busy_vld_o), 1);
        mode = 0;
        s_prst = 1; step(); step();
        chk(busy_vld_o == 0, "R9 record dropped", 32'(busy_vld_o), 0);
        chk(issue_o[7] == 1, "R9 bit untouched", 32'(issue_o[7]), 1);
        repeat (50) step();
        chk(issue_o == 0, "R9 slot served later", issue_o, 0);

        // R11: trigger during a walk starts a new walk from slot 0
        mode = 0; disp_q.delete();
        write_bits((32'h1 << 10) | (32'h1 << 20));
        step();
        write_bits(32'h1 << 2);
        repeat (15) step();
        chk(pack_q() == 32'h000B1503, "R11 remembered trigger", pack_q(), 32'h000B1503);

        // random traffic against the model
        mode = 2; lat_lo = 1; lat_hi = 8;
        for (int k = 0; k < 4000; k++) begin
            s_start = ($urandom % 64) != 0;
            s_wr    = ($urandom % 6) == 0;
            s_wdata = $urandom & $urandom & $urandom;
            f_busy  = ($urandom % 25) == 0;
            s_done  = ($urandom % 60) == 0;
            s_prst  = ($urandom % 300) == 0;
            step();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule